// File: doc/BRIEF.md
# Serial LED Shift Controller

This peripheral drives a chain of external 8-bit shift registers. The chain is commonly used to fan out many LED lines from three pins: serial data, shift clock and a store strobe. Software writes an output image of up to three 8-bit groups through a small 32-bit register bus and asks for a transfer. The block then serializes the image onto the chain and pulses the store strobe, so every parallel output changes at the same moment.

Transfers can also run on a timer. When the timer is enabled it fires at one of four selectable rates, and a prescaler parameter derives those rates from the bus clock. Any of the eight lowest image bits can be handed to hardware status inputs: two from a DSL core and three from each of two PHYs. Those bits then follow the status lines instead of the CPU data. The clock edge on which the external registers sample data can be programmed.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, word 0x00 reads 0x0400_0000 (falling edge selected), word 0x04 reads 0x0000_0001 (lowest group enabled), word 0x08 reads 0, the shift clock sits high, and data and store are low.
- R2: The words are addressed by byte offset 0x00, 0x04, 0x08, 0x0C and 0x10. Implemented bits read back as written. Bit 31 of word 0x00 always reads 0. Any other offset, and any offset with bits 1:0 non-zero, reads 0 and ignores writes.
- R3: A write to word 0x00 with bit 31 set starts a frame. The frame carries the image held in word 0x08, bits 23:0, captured at frame start. Later writes to word 0x08 do not alter a frame that is in progress.
- R4: Bits 2:0 of word 0x04 enable the groups. A frame shifts 8·(h+1) bits, where h is the index of the highest set enable bit. With no group enabled, a request produces no frame.
- R5: Bits leave the block most significant first. After a frame of n bits, the downstream chain holds image bits n-1..0, with bit 0 nearest the data input.
- R6: Bit 26 of word 0x00 sets the edge. With bit 26 at 1, the shift clock idles high and data is taken on its falling edge. With bit 26 at 0, it idles low and data is taken on its rising edge. Serial data never changes at a sampling edge.
- R7: After the last bit, store goes high for exactly 2·SCK_HALF bus cycles. The shift clock stays at its idle level during that time.
- R8: Word 0x00 bits 25:24 give image bits 1:0 to the DSL status inputs 1:0. Word 0x00 bits 29:27 give image bits 4:2 to PHY-A inputs 2:0. Word 0x04 bits 17:15 give image bits 7:5 to PHY-B inputs 2:0. Status is sampled at frame start.
- R9: Auto updates run only when word 0x04 bits 31:30 equal 2'b10 (bus clock). Word 0x04 bits 24:23 set the rate: 0, 1, 2 and 3 give 2, 4, 8 and 10 Hz, which is a frame every 20, 10, 5 and 4 times TICK_DIV bus cycles.
- R10: A request that arrives during a frame is held and served right after that frame. Several requests during one frame yield one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| dsl_led_in | input | 2 | DSL core status lines |
| phya_led_in | input | 3 | PHY-A status lines |
| phyb_led_in | input | 3 | PHY-B status lines |
| sclk_o | output | 1 | Shift clock to chain |
| sdo_o | output | 1 | Serial data to chain |
| store_o | output | 1 | Store strobe to chain |

## Verification
The bound checker checks four things on every cycle:
- serial data holds steady across each sampling edge;
- the number of sampling edges before each store pulse equals the latched frame length;
- every store pulse has exact width;
- the shift clock stays quiet while store is high.

Only the bench's scenarios can show the rest. That covers the chain contents after a frame, including bit order and the per-bit hardware override. It also covers register readback, the auto-update intervals at each rate, and the merging of requests held during a busy frame.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   localparam int MAX_GRP = 3;
   localparam int HW_BITS = 8;

   // word index = byte offset / 4
   localparam logic [2:0] W_CTL_A = 3'd0;
   localparam logic [2:0] W_CTL_B = 3'd1;
   localparam logic [2:0] W_DAT_A = 3'd2;
   localparam logic [2:0] W_DAT_B = 3'd3;
   localparam logic [2:0] W_ACC   = 3'd4;

   // field positions
   localparam int A_GO       = 31;
   localparam int A_PHYA_LSB = 27;
   localparam int A_EDGE     = 26;
   localparam int A_DSL_LSB  = 24;
   localparam int B_SRC_LSB  = 30;
   localparam int B_RATE_LSB = 23;
   localparam int B_PHYB_LSB = 15;

   localparam logic [1:0] SRC_BUSCLK = 2'b10;

   typedef struct packed {
      logic               edge_fall;
      logic [1:0]         dsl_own;
      logic [2:0]         phya_own;
      logic [2:0]         phyb_own;
      logic [MAX_GRP-1:0] grp_en;
      logic [1:0]         auto_src;
      logic [1:0]         rate;
   } lsc_cfg_t;

   typedef enum logic [1:0] {SER_IDLE, SER_SHIFT, SER_LATCH} ser_state_t;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
   import lsc_pkg::*;
#(
   parameter int IMG_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [4:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output lsc_cfg_t         cfg,
   output logic [IMG_W-1:0] image,
   output logic             go
);
   logic [2:0]  widx;
   logic        aligned;
   logic [31:0] datb_q, acc_q;

   assign widx    = bus_addr[4:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign go      = bus_wr && aligned && (widx == W_CTL_A) && bus_wdata[A_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '{edge_fall: 1'b1, grp_en: 3'b001, default: '0};
         image  <= '0;
         datb_q <= '0;
         acc_q  <= '0;
      end else if (bus_wr && aligned) begin
         case (widx)
            W_CTL_A: begin
               cfg.edge_fall <= bus_wdata[A_EDGE];
               cfg.dsl_own   <= bus_wdata[A_DSL_LSB +: 2];
               cfg.phya_own  <= bus_wdata[A_PHYA_LSB +: 3];
            end
            W_CTL_B: begin
               cfg.auto_src <= bus_wdata[B_SRC_LSB +: 2];
               cfg.rate     <= bus_wdata[B_RATE_LSB +: 2];
               cfg.phyb_own <= bus_wdata[B_PHYB_LSB +: 3];
               cfg.grp_en   <= bus_wdata[MAX_GRP-1:0];
            end
            W_DAT_A: image  <= bus_wdata[IMG_W-1:0];
            W_DAT_B: datb_q <= bus_wdata;
            W_ACC:   acc_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         case (widx)
            W_CTL_A: begin
               bus_rdata[A_EDGE]            = cfg.edge_fall;
               bus_rdata[A_DSL_LSB +: 2]    = cfg.dsl_own;
               bus_rdata[A_PHYA_LSB +: 3]   = cfg.phya_own;
            end
            W_CTL_B: begin
               bus_rdata[B_SRC_LSB +: 2]    = cfg.auto_src;
               bus_rdata[B_RATE_LSB +: 2]   = cfg.rate;
               bus_rdata[B_PHYB_LSB +: 3]   = cfg.phyb_own;
               bus_rdata[MAX_GRP-1:0]       = cfg.grp_en;
            end
            W_DAT_A: bus_rdata[IMG_W-1:0] = image;
            W_DAT_B: bus_rdata = datb_q;
            W_ACC:   bus_rdata = acc_q;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/lsc_timer.sv
module lsc_timer #(
   parameter int TICK_DIV = 1250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int unsigned LIM_MAX = TICK_DIV * 20;
   localparam int CW = $clog2(LIM_MAX + 1);
   localparam logic [CW-1:0] LIM_2HZ  = CW'(TICK_DIV * 20 - 1);
   localparam logic [CW-1:0] LIM_4HZ  = CW'(TICK_DIV * 10 - 1);
   localparam logic [CW-1:0] LIM_8HZ  = CW'(TICK_DIV * 5 - 1);
   localparam logic [CW-1:0] LIM_10HZ = CW'(TICK_DIV * 4 - 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("lsc_timer: TICK_DIV must be at least 1");
   end

   logic [CW-1:0] cnt, lim;

   always_comb begin
      case (rate)
         2'd0:    lim = LIM_2HZ;
         2'd1:    lim = LIM_4HZ;
         2'd2:    lim = LIM_8HZ;
         default: lim = LIM_10HZ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/lsc_srcmux.sv
module lsc_srcmux
   import lsc_pkg::*;
#(
   parameter int IMG_W = 24
) (
   input  logic [IMG_W-1:0]   cpu_img,
   input  logic [HW_BITS-1:0] hw_own,
   input  logic [HW_BITS-1:0] hw_val,
   output logic [IMG_W-1:0]   frame_img
);
   if (IMG_W < HW_BITS) begin : g_bad_w
      $error("lsc_srcmux: image narrower than the hardware-owned bits");
   end

   for (genvar i = 0; i < IMG_W; i++) begin : g_bit
      if (i < HW_BITS) begin : g_hw
         assign frame_img[i] = hw_own[i] ? hw_val[i] : cpu_img[i];
      end else begin : g_cpu
         assign frame_img[i] = cpu_img[i];
      end
   end
endmodule

// File: rtl/lsc_serializer.sv
module lsc_serializer
   import lsc_pkg::*;
#(
   parameter int GRP_W    = 8,
   parameter int N_GRP    = 3,
   parameter int SCK_HALF = 4,
   parameter int NBW      = $clog2(GRP_W * N_GRP + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req,
   input  logic                     edge_fall,
   input  logic [N_GRP-1:0]         grp_en,
   input  logic [GRP_W*N_GRP-1:0]   img,
   output logic                     sclk,
   output logic                     sdo,
   output logic                     store,
   output logic                     edge_lat,
   output logic [NBW-1:0]           nbits
);
   localparam int IMG_W = GRP_W * N_GRP;
   localparam int BW    = $clog2(IMG_W);
   localparam int HCW   = $clog2(2 * SCK_HALF) + 1;
   localparam logic [HCW-1:0] HALF_END  = HCW'(SCK_HALF - 1);
   localparam logic [HCW-1:0] LATCH_END = HCW'(2 * SCK_HALF - 1);

   if (SCK_HALF < 1) begin : g_bad_half
      $error("lsc_serializer: SCK_HALF must be at least 1");
   end

   ser_state_t       state;
   logic [IMG_W-1:0] sh;
   logic [BW-1:0]    bitidx;
   logic [HCW-1:0]   hcnt;
   logic             phase, pend;
   logic [NBW-1:0]   nb_c;

   // frame length from the highest enabled group
   always_comb begin
      nb_c = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (grp_en[g]) nb_c = NBW'((g + 1) * GRP_W);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SER_IDLE;
         sh       <= '0;
         bitidx   <= '0;
         hcnt     <= '0;
         phase    <= 1'b0;
         pend     <= 1'b0;
         edge_lat <= 1'b1;
         nbits    <= '0;
      end else begin
         case (state)
            SER_IDLE: begin
               edge_lat <= edge_fall;
               pend     <= pend | req;
               if (pend) begin
                  pend <= req;
                  if (nb_c != '0) begin
                     sh     <= img;
                     bitidx <= BW'(nb_c - NBW'(1));
                     nbits  <= nb_c;
                     hcnt   <= '0;
                     phase  <= 1'b0;
                     state  <= SER_SHIFT;
                  end
               end
            end
            SER_SHIFT: begin
               pend <= pend | req;
               if (hcnt == HALF_END) begin
                  hcnt <= '0;
                  if (!phase) begin
                     phase <= 1'b1;
                  end else begin
                     phase <= 1'b0;
                     if (bitidx == '0) state <= SER_LATCH;
                     else              bitidx <= bitidx - 1'b1;
                  end
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: begin
               pend <= pend | req;
               if (hcnt == LATCH_END) begin
                  hcnt  <= '0;
                  state <= SER_IDLE;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign sclk  = edge_lat ^ ((state == SER_SHIFT) && phase);
   assign sdo   = (state == SER_SHIFT) ? sh[bitidx] : 1'b0;
   assign store = (state == SER_LATCH);
endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
   import lsc_pkg::*;
#(
   parameter int TICK_DIV = 1250000,
   parameter int SCK_HALF = 4,
   parameter int GRP_W    = 8,
   parameter int N_GRP    = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [1:0]  dsl_led_in,
   input  logic [2:0]  phya_led_in,
   input  logic [2:0]  phyb_led_in,
   output logic        sclk_o,
   output logic        sdo_o,
   output logic        store_o
);
   localparam int IMG_W = GRP_W * N_GRP;
   localparam int NBW   = $clog2(IMG_W + 1);

   if (N_GRP < 1 || N_GRP > MAX_GRP) begin : g_bad_grp
      $error("led_shift_ctrl: N_GRP out of range");
   end
   if (GRP_W < HW_BITS || IMG_W > 32) begin : g_bad_width
      $error("led_shift_ctrl: group width out of range");
   end

   lsc_cfg_t         cfg;
   logic [IMG_W-1:0] cpu_img, frame_img;
   logic             sw_go, tick, edge_lat;
   logic [NBW-1:0]   frame_bits;

   lsc_regs #(.IMG_W(IMG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg       (cfg),
      .image     (cpu_img),
      .go        (sw_go)
   );

   lsc_timer #(.TICK_DIV(TICK_DIV)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg.auto_src == SRC_BUSCLK),
      .rate  (cfg.rate),
      .tick  (tick)
   );

   lsc_srcmux #(.IMG_W(IMG_W)) u_mux (
      .cpu_img   (cpu_img),
      .hw_own    ({cfg.phyb_own, cfg.phya_own, cfg.dsl_own}),
      .hw_val    ({phyb_led_in, phya_led_in, dsl_led_in}),
      .frame_img (frame_img)
   );

   lsc_serializer #(
      .GRP_W    (GRP_W),
      .N_GRP    (N_GRP),
      .SCK_HALF (SCK_HALF),
      .NBW      (NBW)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (sw_go | tick),
      .edge_fall (cfg.edge_fall),
      .grp_en    (cfg.grp_en[N_GRP-1:0]),
      .img       (frame_img),
      .sclk      (sclk_o),
      .sdo       (sdo_o),
      .store     (store_o),
      .edge_lat  (edge_lat),
      .nbits     (frame_bits)
   );
endmodule

// File: rtl/led_shift_ctrl_chk.sv
module led_shift_ctrl_chk #(
   parameter int SCK_HALF = 4,
   parameter int NBW      = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sclk,
   input logic           sdo,
   input logic           store,
   input logic           edge_lat,
   input logic [NBW-1:0] nbits
);
   logic           prev_sclk, prev_sdo, prev_store;
   logic [NBW-1:0] act_cnt;
   logic [15:0]    st_cnt;
   logic           act;

   // a sampling edge: clock leaves its idle level outside a store pulse
   assign act = !store && (sclk != prev_sclk) && (sclk != edge_lat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk  <= 1'b1;
         prev_sdo   <= 1'b0;
         prev_store <= 1'b0;
         act_cnt    <= '0;
         st_cnt     <= '0;
      end else begin
         prev_sclk  <= sclk;
         prev_sdo   <= sdo;
         prev_store <= store;
         st_cnt     <= store ? st_cnt + 1'b1 : '0;
         if (!store && prev_store) act_cnt <= '0;
         else if (act)             act_cnt <= act_cnt + 1'b1;
      end
   end

   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (sdo == prev_sdo)); // R6

   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (store && !prev_store) |-> (act_cnt == nbits)); // R4

   AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!store && prev_store) |-> (st_cnt == 16'(2 * SCK_HALF))); // R7

   AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      store |-> (sclk == edge_lat)); // R7
endmodule

bind led_shift_ctrl led_shift_ctrl_chk #(.SCK_HALF(SCK_HALF), .NBW(NBW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk     (sclk_o),
   .sdo      (sdo_o),
   .store    (store_o),
   .edge_lat (edge_lat),
   .nbits    (frame_bits)
);

// File: tb/led_shift_ctrl_tb.sv
module led_shift_ctrl_tb;
   localparam int TD = 8;
   localparam int SH = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [1:0]  dsl_in;
   logic [2:0]  phya_in, phyb_in;
   logic        sclk_o, sdo_o, store_o;

   always #10 clk = ~clk;

   led_shift_ctrl #(.TICK_DIV(TD), .SCK_HALF(SH), .GRP_W(8), .N_GRP(3)) u_dut (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .dsl_led_in (dsl_in),
      .phya_led_in (phya_in), .phyb_led_in (phyb_in), .sclk_o (sclk_o),
      .sdo_o (sdo_o), .store_o (store_o)
   );

   int errs = 0, checks = 0;
   bit done = 1'b0;

   // model of the external chain
   bit          cur_fall = 1'b1;
   bit          prev_s = 1'b1, prev_st = 1'b0;
   int          shifts = 0, shifts_at_store = 0, frames = 0;
   int          st_len = 0, last_len = 0, cyc = 0, rise_last = 0, rise_prev = 0;
   logic [31:0] sr = '0, latched = '0;
   logic [31:0] hist [8];

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!store_o && ((cur_fall && prev_s && !sclk_o) || (!cur_fall && !prev_s && sclk_o))) begin
            sr = {sr[30:0], sdo_o};
            shifts++;
         end
         if (store_o && !prev_st) begin
            latched = sr;
            if (frames < 8) hist[frames] = sr;
            frames++;
            rise_prev = rise_last;
            rise_last = cyc;
            shifts_at_store = shifts;
            shifts = 0;
         end
         if (store_o) st_len++;
         if (!store_o && prev_st) begin
            last_len = st_len;
            st_len = 0;
         end
      end
      prev_s  = sclk_o;
      prev_st = store_o;
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
      checks++;
      if (got !== want) begin
         errs++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, want);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic clear_mon();
      @(posedge clk);
      #1;
      frames = 0; shifts = 0; shifts_at_store = 0; last_len = 0;
   endtask

   task automatic wait_frames(input int n, input int maxc);
      for (int i = 0; i < maxc && frames < n; i++) @(negedge clk);
      repeat (2 * SH + 3) @(negedge clk);
   endtask

   function automatic logic [31:0] ctl_a(input bit go, input bit fe, input logic [1:0] dsl, input logic [2:0] pa);
      return (32'(go) << 31) | (32'(pa) << 27) | (32'(fe) << 26) | (32'(dsl) << 24);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, pat, stat_v, m8, want;
      int n, h;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      dsl_in = '0; phya_in = '0; phyb_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h00, v); chk("R1 ctl_a", v, 32'h0400_0000);
      rd(5'h04, v); chk("R1 ctl_b", v, 32'h0000_0001);
      rd(5'h08, v); chk("R1 data", v, 32'h0);
      chk("R1 sclk idle", 32'(sclk_o), 32'h1);
      chk("R1 store", 32'(store_o), 32'h0);
      chk("R1 sdo", 32'(sdo_o), 32'h0);

      // R2 register map
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h09, 32'h0);
      rd(5'h00, v); chk("R2 ctl_a", v, 32'h3F00_0000);
      rd(5'h04, v); chk("R2 ctl_b", v, 32'hC183_8007);
      rd(5'h08, v); chk("R2 data", v, 32'h00FF_FFFF);
      rd(5'h0C, v); chk("R2 word3", v, 32'hFFFF_FFFF);
      rd(5'h10, v); chk("R2 word4", v, 32'hFFFF_FFFF);
      rd(5'h14, v); chk("R2 unmapped", v, 32'h0);
      rd(5'h09, v); chk("R2 misaligned", v, 32'h0);
      wr(5'h00, ctl_a(0, 1, 2'b00, 3'b000));
      wr(5'h04, 32'h1);
      repeat (80) @(negedge clk);

      // R3 R4 R5 R6 R7 sweep over edge and group enables
      for (int fe = 0; fe < 2; fe++) begin
         for (int g = 1; g < 8; g++) begin
            wr(5'h04, 32'(g));
            wr(5'h00, ctl_a(0, fe[0], 2'b00, 3'b000));
            repeat (3) @(negedge clk);
            cur_fall = fe[0];
            pat = (32'h00A5_C396 ^ (32'(g) * 32'h0013_5719) ^ (32'(fe) << 23)) & 32'h00FF_FFFF;
            wr(5'h08, pat);
            clear_mon();
            wr(5'h00, ctl_a(1, fe[0], 2'b00, 3'b000));
            wait_frames(1, 400);
            h = 0;
            for (int b = 0; b < 3; b++) if (g[b]) h = b;
            n = 8 * (h + 1);
            chk("R3 one frame", 32'(frames), 32'h1);
            chk("R4 frame length", 32'(shifts_at_store), 32'(n));
            chk("R5 chain contents", latched & ((32'h1 << n) - 1), pat & ((32'h1 << n) - 1));
            chk("R7 store width", 32'(last_len), 32'(2 * SH));
            chk("R6 idle level", 32'(sclk_o), 32'(fe));
         end
      end

      // R4 no groups enabled
      wr(5'h04, 32'h0);
      clear_mon();
      wr(5'h00, ctl_a(1, 1, 2'b00, 3'b000));
      repeat (100) @(negedge clk);
      chk("R4 no group no frame", 32'(frames), 32'h0);

      // R8 exhaustive ownership masks
      for (int m = 0; m < 256; m++) begin
         m8     = 32'(m);
         stat_v = (32'(m) * 32'd37 + 32'd11) & 32'hFF;
         pat    = ((~32'(m)) * 32'd53 + 32'h4C) & 32'hFF;
         dsl_in  = stat_v[1:0];
         phya_in = stat_v[4:2];
         phyb_in = stat_v[7:5];
         wr(5'h04, (32'(m8[7:5]) << 15) | 32'h1);
         wr(5'h08, pat);
         clear_mon();
         wr(5'h00, ctl_a(1, 1, m8[1:0], m8[4:2]));
         wait_frames(1, 200);
         want = (pat & ~m8 & 32'hFF) | (stat_v & m8);
         chk("R8 override", latched & 32'hFF, want);
      end
      wr(5'h00, ctl_a(0, 1, 2'b00, 3'b000));
      wr(5'h04, 32'h7);

      // R10 requests held during a frame; R3 capture at start
      wr(5'h08, 32'h005A_3C81);
      clear_mon();
      wr(5'h00, ctl_a(1, 1, 2'b00, 3'b000));
      repeat (6) @(negedge clk);
      wr(5'h08, 32'h00C3_0F7E);
      wr(5'h00, ctl_a(1, 1, 2'b00, 3'b000));
      wr(5'h00, ctl_a(1, 1, 2'b00, 3'b000));
      wait_frames(2, 600);
      repeat (100) @(negedge clk);
      chk("R10 merged frames", 32'(frames), 32'h2);
      chk("R3 first frame image", hist[0] & 32'h00FF_FFFF, 32'h005A_3C81);
      chk("R10 held frame image", hist[1] & 32'h00FF_FFFF, 32'h00C3_0F7E);

      // R9 auto update rates
      for (int r = 0; r < 4; r++) begin
         wr(5'h04, (32'h2 << 30) | (32'(r) << 23) | 32'h1);
         clear_mon();
         wait_frames(3, 1000);
         case (r)
            0: n = TD * 20;
            1: n = TD * 10;
            2: n = TD * 5;
            default: n = TD * 4;
         endcase
         chk("R9 auto period", 32'(rise_last - rise_prev), 32'(n));
      end
      wr(5'h04, (32'h1 << 30) | 32'h1);
      repeat (5) @(negedge clk);
      clear_mon();
      repeat (400) @(negedge clk);
      chk("R9 other source idle", 32'(frames), 32'h0);
      wr(5'h04, 32'h1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule